// File: doc/BRIEF.md
# Divider Configuration Loader

This block keeps the configuration word of a clock synthesizer: a 9-bit feedback divide value, a 2-bit output divide select and a 3-bit test select. Software or board logic can set the word in two ways. The first is a parallel bus, which is transparent while an active-low load pin is held low. The second is a three-wire serial port with a bit clock, a data line and a load strobe. All control pins arrive without any timing relation to the system clock. They are resynchronized, and edge events are derived from them inside the system clock domain.

The active divide values follow the parallel bus while the load pin is low, and they freeze when the pin rises. A serial word is shifted in MSB-first. It reaches the active values when the strobe rises, stays frozen after the strobe falls, and tracks each shifted bit while the strobe stays high. A flag marks any feedback value too small for the loop to lock. The bit at the far end of the shift register is brought out so that it can be read back.

Top module: `divcfg_loader`

## Requirements
- R1: After reset the active feedback value is all ones (511), the output select is 11, the test select is 000, the shift tail is 0 and the low flag is 0.
- R2: While `par_load_n` is low, `m_active` and `n_active` follow `par_m` and `par_n` within four system clocks, and `t_active` is 000.
- R3: When `par_load_n` rises, the last bus value is held. Later changes on `par_m` and `par_n` have no effect.
- R4: While `par_load_n` is high, each rising `ser_clk` shifts `ser_data` into bit 0 of a 14-bit register. `shift_tail` shows bit 13, which is the bit shifted in 13 edges earlier.
- R5: The serial word is sent test bits first (T2, T1, T0), then N1, N0, then M8 down to M0. After 14 shifts, bits 13:11 hold T, bits 10:9 hold N and bits 8:0 hold M. The N codes 00, 01, 10 and 11 mean divide by 1, 2, 4 and 8.
- R6: A rising `ser_strobe` copies the shift register fields into `m_active`, `n_active` and `t_active`.
- R7: While `ser_strobe` is low, serial shifting does not change the active values. After the strobe falls, the loaded values are held.
- R8: While `ser_strobe` is high, each rising `ser_clk` places the newly shifted word straight into the active values.
- R9: A serial load replaces values that were captured through the parallel bus.
- R10: `ser_clk` edges while `par_load_n` is low leave the shift register unchanged.
- R11: `m_low_flag` is 1 exactly when `m_active` is below 200. The flag is 0 at 200 and 1 at 199.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| par_load_n | input | 1 | Parallel transparent when low; captures on rise |
| par_m | input | 9 | Parallel feedback divide value |
| par_n | input | 2 | Parallel output divide select |
| ser_clk | input | 1 | Serial bit clock |
| ser_data | input | 1 | Serial data bit |
| ser_strobe | input | 1 | Serial load strobe |
| m_active | output | 9 | Active feedback divide value |
| n_active | output | 2 | Active output divide select |
| t_active | output | 3 | Active test select |
| shift_tail | output | 1 | Far end of the shift register |
| m_low_flag | output | 1 | Active feedback value below lock minimum |

## Verification
The bench builds the block with its default parameters: a two-stage synchronizer, 9/2/3 field widths and a lock minimum of 200. With these values a whole serial word is 14 shifts, so every field position can be checked through a few complete words. The 199/200 boundary of the flag can be reached from the parallel bus and from the serial port. The fixed synchronizer depth sets a settling time of three system clocks. The bench waits longer than that after each pin change, so every check is independent of the exact edge on which the change lands.

// File: rtl/cfgld_pkg.sv
package cfgld_pkg;
  localparam int unsigned DEF_M_W   = 9;
  localparam int unsigned DEF_N_W   = 2;
  localparam int unsigned DEF_T_W   = 3;
  localparam int unsigned DEF_M_MIN = 200;

  // True when a feedback value cannot reach lock.
  function automatic logic m_unlockable(input int unsigned m, input int unsigned mmin);
    return (m < mmin);
  endfunction

  // Output divide ratio selected by an N code: 1, 2, 4, 8.
  function automatic int unsigned n_ratio(input int unsigned code);
    return 32'd1 << code;
  endfunction
endpackage

// File: rtl/cfgld_sync.sv
module cfgld_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] chain [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[g] <= RST_VAL;
        else if (g == 0) chain[g] <= async_in;
        else chain[g] <= chain[(g == 0) ? 0 : g-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/cfgld_shifter.sv
module cfgld_shifter #(
  parameter int unsigned SH_W = 14
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            shift_en,
  input  logic            din,
  output logic [SH_W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else if (shift_en) q <= {q[SH_W-2:0], din};
  end

  // R10
  shreg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shift_en |=> $stable(q));
  // R4
  shreg_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (q[0] == $past(din)) && (q[SH_W-1:1] == $past(q[SH_W-2:0])));
endmodule

// File: rtl/cfgld_select.sv
module cfgld_select #(
  parameter int unsigned M_W = 9,
  parameter int unsigned N_W = 2,
  parameter int unsigned T_W = 3,
  localparam int unsigned SH_W = M_W + N_W + T_W
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            par_mode,
  input  logic            pl_rise,
  input  logic            sl_lvl,
  input  logic            sl_rise,
  input  logic            sl_fall,
  input  logic            sc_rise,
  input  logic [M_W-1:0]  par_m,
  input  logic [N_W-1:0]  par_n,
  input  logic [SH_W-1:0] sh_q,
  input  logic            sh_din,
  output logic [M_W-1:0]  m_q,
  output logic [N_W-1:0]  n_q,
  output logic [T_W-1:0]  t_q
);
  logic [SH_W-1:0] next_word;
  logic            pass_evt;
  logic            load_evt;

  assign next_word = {sh_q[SH_W-2:0], sh_din};
  assign load_evt  = !par_mode && sl_rise;
  assign pass_evt  = !par_mode && !sl_rise && sl_lvl && sc_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= '1;
      n_q <= '1;
      t_q <= '0;
    end else if (par_mode) begin
      m_q <= par_m;
      n_q <= par_n;
      t_q <= '0;
    end else if (load_evt) begin
      m_q <= sh_q[M_W-1:0];
      n_q <= sh_q[M_W +: N_W];
      t_q <= sh_q[M_W+N_W +: T_W];
    end else if (pass_evt) begin
      m_q <= next_word[M_W-1:0];
      n_q <= next_word[M_W +: N_W];
      t_q <= next_word[M_W+N_W +: T_W];
    end
  end

  // R2
  par_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    par_mode |=> (m_q == $past(par_m)) && (n_q == $past(par_n)) && (t_q == '0));
  // R3
  par_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_rise && !sl_rise && !(sl_lvl && sc_rise)) |=> $stable(m_q) && $stable(n_q));
  // R6
  ser_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (m_q == $past(sh_q[M_W-1:0])) && (t_q == $past(sh_q[SH_W-1 -: T_W])));
  // R7
  strobe_fall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && sl_fall) |=> $stable(m_q) && $stable(n_q) && $stable(t_q));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_mode && !sl_lvl && !sl_rise) |=> $stable(m_q) && $stable(n_q) && $stable(t_q));
endmodule

// File: rtl/divcfg_loader.sv
module divcfg_loader
  import cfgld_pkg::*;
#(
  parameter int unsigned M_W         = DEF_M_W,
  parameter int unsigned N_W         = DEF_N_W,
  parameter int unsigned T_W         = DEF_T_W,
  parameter int unsigned M_MIN       = DEF_M_MIN,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           par_load_n,
  input  logic [M_W-1:0] par_m,
  input  logic [N_W-1:0] par_n,
  input  logic           ser_clk,
  input  logic           ser_data,
  input  logic           ser_strobe,
  output logic [M_W-1:0] m_active,
  output logic [N_W-1:0] n_active,
  output logic [T_W-1:0] t_active,
  output logic           shift_tail,
  output logic           m_low_flag
);
  localparam int unsigned SH_W = M_W + N_W + T_W;
  // bit order in sync vector: 3 = par_load_n, 2 = strobe, 1 = ser_clk, 0 = data
  localparam logic [3:0]  SYNC_RST = 4'b1000;

  logic [3:0]      sync_lvl;
  logic [3:1]      prev_lvl;
  logic            pl_lvl, sl_lvl, sc_lvl, sd_lvl;
  logic            pl_rise, sl_rise, sl_fall, sc_rise;
  logic            shift_en;
  logic [SH_W-1:0] sh_q;

  cfgld_sync #(.WIDTH(4), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in ({par_load_n, ser_strobe, ser_clk, ser_data}),
    .sync_out (sync_lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_lvl <= SYNC_RST[3:1];
    else        prev_lvl <= sync_lvl[3:1];
  end

  assign pl_lvl  = sync_lvl[3];
  assign sl_lvl  = sync_lvl[2];
  assign sc_lvl  = sync_lvl[1];
  assign sd_lvl  = sync_lvl[0];
  assign pl_rise = pl_lvl & ~prev_lvl[3];
  assign sl_rise = sl_lvl & ~prev_lvl[2];
  assign sl_fall = ~sl_lvl & prev_lvl[2];
  assign sc_rise = sc_lvl & ~prev_lvl[1];
  assign shift_en = sc_rise & pl_lvl;

  cfgld_shifter #(.SH_W(SH_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .shift_en (shift_en),
    .din      (sd_lvl),
    .q        (sh_q)
  );

  cfgld_select #(.M_W(M_W), .N_W(N_W), .T_W(T_W)) u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .par_mode (~pl_lvl),
    .pl_rise  (pl_rise),
    .sl_lvl   (sl_lvl),
    .sl_rise  (sl_rise),
    .sl_fall  (sl_fall),
    .sc_rise  (sc_rise),
    .par_m    (par_m),
    .par_n    (par_n),
    .sh_q     (sh_q),
    .sh_din   (sd_lvl),
    .m_q      (m_active),
    .n_q      (n_active),
    .t_q      (t_active)
  );

  assign shift_tail = sh_q[SH_W-1];
  assign m_low_flag = m_unlockable(int'(m_active), M_MIN);

  // R8
  pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pl_lvl && sl_lvl && !sl_rise && sc_rise) |=> (m_active[0] == $past(sd_lvl)));
  // R4
  tail_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_en |=> (shift_tail == $past(sh_q[SH_W-2])));
endmodule

// File: tb/sim_divcfg_loader.sv
module sim_divcfg_loader;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       par_load_n = 1;
  logic [8:0] par_m = '0;
  logic [1:0] par_n = '0;
  logic       ser_clk = 0, ser_data = 0, ser_strobe = 0;
  logic [8:0] m_active;
  logic [1:0] n_active;
  logic [2:0] t_active;
  logic       shift_tail, m_low_flag;

  int tests = 0, fails = 0;
  logic [13:0] model = '0;
  bit done = 0;

  always #2 clk = ~clk;

  divcfg_loader u0 (.*);

  // entry: {m[8:0], n[1:0], expected flag}
  localparam logic [11:0] PVEC [8] = '{
    {9'd200, 2'd0, 1'b0}, {9'd199, 2'd1, 1'b1}, {9'd0,   2'd2, 1'b1},
    {9'd511, 2'd3, 1'b0}, {9'd300, 2'd1, 1'b0}, {9'd128, 2'd2, 1'b1},
    {9'd201, 2'd0, 1'b0}, {9'd255, 2'd3, 1'b0}};

  task automatic settle(int n = 5);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, int got, int exp);
    tests++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s got=%0d exp=%0d", req, got, exp);
    end
  endtask

  task automatic chk_out(string req, int m, int n, int t);
    chk(req, m_active, m);
    chk(req, n_active, n);
    chk(req, t_active, t);
    chk(req, m_low_flag, (m < 200) ? 1 : 0);
  endtask

  task automatic clk_bit(logic b, bit track);
    ser_data = b; settle(4);
    ser_clk = 1;  settle(4);
    ser_clk = 0;  settle(4);
    if (track) model = {model[12:0], b};
  endtask

  task automatic send_word(int t, int n, int m);
    logic [13:0] w;
    w = {t[2:0], n[1:0], m[8:0]};
    for (int i = 13; i >= 0; i--) clk_bit(w[i], 1);
  endtask

  task automatic strobe_pulse();
    ser_strobe = 1; settle(6);
    ser_strobe = 0; settle(6);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    settle(3);
    rst_n = 1;
    settle(3);
    // R1 reset state
    chk_out("R1", 511, 3, 0);
    chk("R1 tail", shift_tail, 0);

    // R2 / R11 parallel table
    par_load_n = 0;
    for (int i = 0; i < 8; i++) begin
      par_m = PVEC[i][11:3];
      par_n = PVEC[i][2:1];
      settle(6);
      chk_out("R2", PVEC[i][11:3], PVEC[i][2:1], 0);
      chk("R11 flag", m_low_flag, PVEC[i][0]);
    end

    // R3 capture on rise
    par_m = 9'd300; par_n = 2'd2; settle(6);
    par_load_n = 1; settle(6);
    par_m = 9'd400; par_n = 2'd0; settle(6);
    chk_out("R3", 300, 2, 0);

    // R4/R5/R7: shift word, outputs unchanged until strobe
    send_word(5, 1, 421);
    chk_out("R7 no load", 300, 2, 0);
    chk("R4 tail", shift_tail, 1);
    // R6/R9 strobe loads, replacing parallel capture
    strobe_pulse();
    chk_out("R6 R9 R5", 421, 1, 5);

    // R7 hold after strobe fall while shifting
    send_word(0, 3, 250);
    chk_out("R7 hold", 421, 1, 5);
    chk("R4 tail", shift_tail, 0);
    strobe_pulse();
    chk_out("R6", 250, 3, 0);

    // R8 pass-through with strobe held high
    ser_strobe = 1; settle(6);
    chk_out("R8 entry", model[8:0], model[10:9], model[13:11]);
    clk_bit(1, 1);
    chk_out("R8", model[8:0], model[10:9], model[13:11]);
    clk_bit(1, 1);
    chk_out("R8", model[8:0], model[10:9], model[13:11]);
    clk_bit(0, 1);
    chk_out("R8", model[8:0], model[10:9], model[13:11]);
    ser_strobe = 0; settle(6);
    chk_out("R7 fall", model[8:0], model[10:9], model[13:11]);

    // R10 serial clocks in parallel mode do not shift
    par_m = 9'd210; par_n = 2'd1; par_load_n = 0; settle(6);
    for (int i = 0; i < 5; i++) clk_bit(~model[13], 0);
    chk("R10 tail", shift_tail, model[13]);
    chk_out("R2", 210, 1, 0);
    par_load_n = 1; settle(6);
    strobe_pulse();
    chk_out("R10 contents", model[8:0], model[10:9], model[13:11]);

    // R11 boundary through serial port
    send_word(2, 0, 199);
    strobe_pulse();
    chk_out("R11 199", 199, 0, 2);
    send_word(7, 2, 200);
    strobe_pulse();
    chk_out("R11 200", 200, 2, 7);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule